// File: doc/BRIEF.md
# Eighth-Sample Chroma Phase Interpolator

This block produces every fractional chroma position at eighth-sample precision from a window of four consecutive samples. Eight fixed-coefficient 4-tap operators work side by side on the same window. Seven of them cover fractions 1/8 through 7/8, and the eighth is a unit-gain pass of the centre sample. All eight results are captured in one pipeline register. The seven fractional results leave on a wide bus, and a 3-bit fraction select picks one of the eight results for a single narrow output.

One instance serves both passes of a separable interpolator. In the first pass the window holds 8-bit pixels (zero-extended to 16 bits) and pixel mode clips each result to the 8-bit range. In the second pass the window holds signed 16-bit results of the first pass that share one horizontal phase. With pixel mode low, the results are only saturated to the signed 16-bit range. Fetching samples and sequencing blocks are left to the surrounding logic.

Top module: `chroma_eighth_interp`

## Requirements
- R1: Window words are ordered `tapPrev` (offset -1), `tapCur` (offset 0), `tapNext` (+1) and `tapNext2` (+2). For fraction k = 1..7 the weights on those words are, in order: k=1 (-2,58,10,-2), k=2 (-4,54,16,-2), k=3 (-6,46,28,-4), k=4 (-4,36,36,-4), k=5 (-4,28,46,-6), k=6 (-2,16,54,-4), k=7 (-2,10,58,-2).
- R2: Each weighted sum S becomes (S + 32) arithmetically shifted right by 6.
- R3: With `pixelMode` = 1, every result is clipped to 0..255.
- R4: With `pixelMode` = 0, every result is saturated to -32768..32767.
- R5: `selOut` carries the result for `fracSel`. Values 1..7 pick phase k. Value 0 returns `tapCur` under the same clip or saturation as R3/R4.
- R6: Results and `outValid` appear one clock after the input cycle that has `inValid` high, and `outValid` is low in every other cycle.
- R7: While `inValid` is low, `selOut` and `phaseBus` hold their last values, whatever the other inputs do.
- R8: After reset, `outValid`, `selOut` and `phaseBus` are all zero.
- R9: `phaseBus` packs phase k in bits [16k-1 : 16k-16]. With the window reversed (tapNext2, tapNext, tapCur, tapPrev moved to tapPrev, tapCur, tapNext, tapNext2), phase k equals phase 8-k of the original window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Window and controls are valid this cycle |
| pixelMode | input | 1 | 1: clip to 8-bit pixel range; 0: saturate to signed 16-bit |
| fracSel | input | 3 | Fraction chosen for selOut (0 = integer position) |
| tapPrev | input | 16 | Signed sample at offset -1 |
| tapCur | input | 16 | Signed sample at offset 0 |
| tapNext | input | 16 | Signed sample at offset +1 |
| tapNext2 | input | 16 | Signed sample at offset +2 |
| phaseBus | output | 112 | Registered results for phases 1..7, 16 bits each |
| selOut | output | 16 | Registered result for the chosen fraction |
| outValid | output | 1 | Results registered from a valid input |

## Verification
Every cycle, the assertions check four behaviours:
- the one-cycle valid alignment;
- that the outputs hold when no valid input arrives;
- the pixel-range bound on the selected output in pixel mode;
- the integer-position pass-through.

The arithmetic itself can only be shown by the bench scenarios. These are the exact coefficient weighting of each phase, the rounding offset, the points where clipping and saturation take over, and the mirror relation between phases k and 8-k. The bench compares every phase of every window against a model it computes itself. The windows are random 8-bit pixels, random signed intermediates, and extreme windows chosen to drive sums past both bounds.

// File: rtl/chroma_interp_pkg.sv
package chroma_interp_pkg;

  localparam int PHASES = 7;
  localparam int NOPS   = PHASES + 1;
  localparam int TAPS   = 4;
  localparam int COEF_W = 8;
  localparam int SHIFT  = 6;
  localparam int FRAC_W = $clog2(NOPS);

  typedef struct packed {
    logic              loadEn;
    logic              pixelMode;
    logic [FRAC_W-1:0] fracSel;
  } dp_ctrl_t;

  // Weight of a tap for a phase; phase 0 is a unit-gain pass of the centre tap.
  function automatic logic signed [COEF_W-1:0] phaseCoef(input int phase, input int tap);
    logic signed [COEF_W-1:0] w [TAPS];
    case (phase)
      0:       w = '{  8'sd0,  8'sd64,  8'sd0,   8'sd0  };
      1:       w = '{ -8'sd2,  8'sd58,  8'sd10, -8'sd2  };
      2:       w = '{ -8'sd4,  8'sd54,  8'sd16, -8'sd2  };
      3:       w = '{ -8'sd6,  8'sd46,  8'sd28, -8'sd4  };
      4:       w = '{ -8'sd4,  8'sd36,  8'sd36, -8'sd4  };
      5:       w = '{ -8'sd4,  8'sd28,  8'sd46, -8'sd6  };
      6:       w = '{ -8'sd2,  8'sd16,  8'sd54, -8'sd4  };
      7:       w = '{ -8'sd2,  8'sd10,  8'sd58, -8'sd2  };
      default: w = '{  8'sd0,  8'sd0,   8'sd0,   8'sd0  };
    endcase
    return w[tap];
  endfunction

endpackage

// File: rtl/chroma_phase_fir.sv
module chroma_phase_fir
  import chroma_interp_pkg::*;
#(
  parameter int PHASE = 1,
  parameter int IN_W  = 16,
  parameter int PIX_W = 8
) (
  input  logic signed [IN_W-1:0] smp [TAPS],
  input  logic                   pixelMode,
  output logic signed [IN_W-1:0] result
);

  localparam int ACC_W = IN_W + COEF_W + 2;
  localparam int HI_I  = 2**(IN_W-1) - 1;
  localparam int LO_I  = -(2**(IN_W-1));
  localparam int PIX_I = 2**PIX_W - 1;
  localparam int RND_I = 2**(SHIFT-1);

  localparam logic signed [ACC_W-1:0] HI_A  = ACC_W'(HI_I);
  localparam logic signed [ACC_W-1:0] LO_A  = ACC_W'(LO_I);
  localparam logic signed [ACC_W-1:0] PIX_A = ACC_W'(PIX_I);
  localparam logic signed [ACC_W-1:0] RND_A = ACC_W'(RND_I);

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] rnd;
  logic signed [ACC_W-1:0] clamped;

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) begin
      acc = acc + ACC_W'(smp[t]) * ACC_W'(phaseCoef(PHASE, t));
    end
  end

  assign rnd = (acc + RND_A) >>> SHIFT;

  always_comb begin
    if (pixelMode) begin
      if (rnd < 0)          clamped = '0;
      else if (rnd > PIX_A) clamped = PIX_A;
      else                  clamped = rnd;
    end else begin
      if (rnd < LO_A)       clamped = LO_A;
      else if (rnd > HI_A)  clamped = HI_A;
      else                  clamped = rnd;
    end
  end

  assign result = IN_W'(clamped);

endmodule

// File: rtl/chroma_interp_ctrl.sv
module chroma_interp_ctrl
  import chroma_interp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              pixelMode,
  input  logic [FRAC_W-1:0] fracSel,
  output dp_ctrl_t          dpCtrl,
  output logic              outValid
);

  always_comb begin
    dpCtrl.loadEn    = inValid;
    dpCtrl.pixelMode = pixelMode;
    dpCtrl.fracSel   = fracSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R6
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R6

endmodule

// File: rtl/chroma_interp_dp.sv
module chroma_interp_dp
  import chroma_interp_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int PIX_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dp_ctrl_t                      dpCtrl,
  input  logic signed [IN_W-1:0]        smp [TAPS],
  output logic [PHASES*IN_W-1:0]        phaseBus,
  output logic signed [IN_W-1:0]        selOut
);

  localparam int PIX_I = 2**PIX_W - 1;

  logic signed [IN_W-1:0] opRes  [NOPS];
  logic signed [IN_W-1:0] phaseQ [PHASES];
  logic signed [IN_W-1:0] selQ;
  logic                   pixQ;

  for (genvar p = 0; p < NOPS; p++) begin : g_op
    chroma_phase_fir #(
      .PHASE (p),
      .IN_W  (IN_W),
      .PIX_W (PIX_W)
    ) op_i (
      .smp       (smp),
      .pixelMode (dpCtrl.pixelMode),
      .result    (opRes[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < PHASES; k++) phaseQ[k] <= '0;
      selQ <= '0;
      pixQ <= 1'b0;
    end else if (dpCtrl.loadEn) begin
      for (int k = 0; k < PHASES; k++) phaseQ[k] <= opRes[k+1];
      selQ <= opRes[dpCtrl.fracSel];
      pixQ <= dpCtrl.pixelMode;
    end
  end

  for (genvar k = 0; k < PHASES; k++) begin : g_bus
    assign phaseBus[k*IN_W +: IN_W] = phaseQ[k];
  end

  assign selOut = selQ;

  AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.loadEn |=> $stable(selOut)); // R7
  AST_HOLD_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.loadEn |=> $stable(phaseBus)); // R7
  AST_PIX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pixQ |-> (selOut >= 0 && selOut <= IN_W'(PIX_I))); // R3
  AST_INT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.loadEn && dpCtrl.fracSel == '0 && !dpCtrl.pixelMode)
      |=> selOut == $past(smp[1])); // R5

endmodule

// File: rtl/chroma_eighth_interp.sv
module chroma_eighth_interp
  import chroma_interp_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int PIX_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     pixelMode,
  input  logic [FRAC_W-1:0]        fracSel,
  input  logic signed [IN_W-1:0]   tapPrev,
  input  logic signed [IN_W-1:0]   tapCur,
  input  logic signed [IN_W-1:0]   tapNext,
  input  logic signed [IN_W-1:0]   tapNext2,
  output logic [PHASES*IN_W-1:0]   phaseBus,
  output logic signed [IN_W-1:0]   selOut,
  output logic                     outValid
);

  dp_ctrl_t               dpCtrl;
  logic signed [IN_W-1:0] win [TAPS];

  assign win[0] = tapPrev;
  assign win[1] = tapCur;
  assign win[2] = tapNext;
  assign win[3] = tapNext2;

  chroma_interp_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .pixelMode (pixelMode),
    .fracSel   (fracSel),
    .dpCtrl    (dpCtrl),
    .outValid  (outValid)
  );

  chroma_interp_dp #(
    .IN_W  (IN_W),
    .PIX_W (PIX_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .smp      (win),
    .phaseBus (phaseBus),
    .selOut   (selOut)
  );

endmodule

// File: tb/chroma_eighth_interp_tb.sv
module chroma_eighth_interp_tb_top;

  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic               pixelMode = 1'b1;
  logic [2:0]         fracSel = '0;
  logic signed [15:0] tapPrev = '0, tapCur = '0, tapNext = '0, tapNext2 = '0;
  logic [111:0]       phaseBus;
  logic signed [15:0] selOut;
  logic               outValid;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chroma_eighth_interp dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pixelMode(pixelMode),
    .fracSel(fracSel), .tapPrev(tapPrev), .tapCur(tapCur), .tapNext(tapNext),
    .tapNext2(tapNext2), .phaseBus(phaseBus), .selOut(selOut), .outValid(outValid)
  );

  function automatic int model(int ph, int a, int b, int c, int d, bit pix);
    int w0, w1, w2, w3, s, r;
    case (ph)
      1: begin w0 = -2; w1 = 58; w2 = 10; w3 = -2; end
      2: begin w0 = -4; w1 = 54; w2 = 16; w3 = -2; end
      3: begin w0 = -6; w1 = 46; w2 = 28; w3 = -4; end
      4: begin w0 = -4; w1 = 36; w2 = 36; w3 = -4; end
      5: begin w0 = -4; w1 = 28; w2 = 46; w3 = -6; end
      6: begin w0 = -2; w1 = 16; w2 = 54; w3 = -4; end
      7: begin w0 = -2; w1 = 10; w2 = 58; w3 = -2; end
      default: begin w0 = 0; w1 = 64; w2 = 0; w3 = 0; end
    endcase
    s = w0*a + w1*b + w2*c + w3*d;
    r = (s + 32) >>> 6;
    if (pix) r = (r < 0) ? 0 : ((r > 255) ? 255 : r);
    else     r = (r < -32768) ? -32768 : ((r > 32767) ? 32767 : r);
    return r;
  endfunction

  function automatic int busPhase(int k);
    return int'($signed(phaseBus[16*k-1 -: 16]));
  endfunction

  task automatic chk(string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(int a, int b, int c, int d, int frac, bit pix);
    string tag;
    @(negedge clk);
    tapPrev = 16'(a); tapCur = 16'(b); tapNext = 16'(c); tapNext2 = 16'(d);
    fracSel = 3'(frac); pixelMode = pix; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    tag = pix ? "R1 R2 R3" : "R1 R2 R4";
    chk("R6 outValid", int'(outValid), 1);
    for (int k = 1; k <= 7; k++) chk(tag, busPhase(k), model(k, a, b, c, d, pix));
    chk("R5 selOut", int'(selOut), model(frac, a, b, c, d, pix));
  endtask

  function automatic int rpix();
    return int'($urandom_range(0, 255));
  endfunction

  function automatic int rint();
    return int'($signed(16'($urandom)));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int keepSel, keepP3;
    int first [8];
    int a, b, c, d;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 outValid", int'(outValid), 0);
    chk("R8 selOut", int'(selOut), 0);
    chk("R8 phaseBus", int'(phaseBus != '0), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 idle outValid", int'(outValid), 0);

    // Pixel mode: every fraction with random windows
    for (int i = 0; i < 160; i++) apply(rpix(), rpix(), rpix(), rpix(), i % 8, 1'b1);
    // Pixel extremes: clip low and high, flat windows
    for (int f = 0; f < 8; f++) begin
      apply(255, 0, 0, 255, f, 1'b1);
      apply(0, 255, 255, 0, f, 1'b1);
      apply(255, 255, 255, 255, f, 1'b1);
      apply(0, 0, 0, 0, f, 1'b1);
      apply(255, 0, 255, 0, f, 1'b1);
    end
    // Intermediate mode: random signed words and saturating extremes
    for (int i = 0; i < 120; i++) apply(rint(), rint(), rint(), rint(), i % 8, 1'b0);
    for (int f = 0; f < 8; f++) begin
      apply(-32768, 32767, 32767, -32768, f, 1'b0);
      apply(32767, -32768, -32768, 32767, f, 1'b0);
      apply(32767, 32767, 32767, 32767, f, 1'b0);
      apply(-32768, -32768, -32768, -32768, f, 1'b0);
      apply(-1, 0, 0, -1, f, 1'b0);
    end

    // R7: outputs hold while inValid is low and inputs change
    apply(10, 200, 30, 90, 3, 1'b1);
    keepSel = int'(selOut);
    keepP3  = busPhase(3);
    @(negedge clk);
    tapPrev = 16'(77); tapCur = 16'(5); tapNext = 16'(250); tapNext2 = 16'(1);
    fracSel = 3'd6; pixelMode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 selOut hold", int'(selOut), keepSel);
    chk("R7 phase3 hold", busPhase(3), keepP3);
    chk("R6 outValid low", int'(outValid), 0);

    // R9: mirror relation between phase k and 8-k
    for (int i = 0; i < 20; i++) begin
      a = rpix(); b = rpix(); c = rpix(); d = rpix();
      apply(a, b, c, d, 0, 1'b1);
      for (int k = 1; k <= 7; k++) first[k] = busPhase(k);
      apply(d, c, b, a, 0, 1'b1);
      for (int k = 1; k <= 7; k++) chk("R9 mirror", busPhase(k), first[8-k]);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule